// File: doc/BRIEF.md
# NaN Format Converter

This combinational unit moves a NaN between the IEEE 754 binary16, binary32 and binary64 encodings. The source value is decoded into a format-neutral form: a sign bit and a 64-bit payload aligned to the left, so the top fraction bit of any source sits at payload bit 63. That form is then re-encoded in the requested destination format. The unit is meant for the NaN-handling path of a floating-point conversion unit. The surrounding datapath sends an operand here once it has found that the operand is a NaN.

When the destination is narrower than the source, the destination fraction is taken from the top of the payload. The low payload bits are dropped. If the remaining fraction is all zero, the pattern would encode an infinity, so the unit emits the configured default NaN instead. A default-NaN mode input makes the unit emit the default NaN in every case. An invalid-operation flag is raised whenever the source is a signaling NaN. The unit does not quieten the payload: a signaling source stays signaling after conversion, unless the default NaN replaces it. Non-NaN sources give an unspecified value and a clear flag.

Format codes: 0 selects binary16, 1 selects binary32, 2 selects binary64, and 3 is treated the same as binary64. A narrow value occupies the low bits of the 64-bit value buses.

Top module: `nan_fmt_conv`

## Requirements
- R1: Widening keeps sign and fraction. The source fraction is placed at the top of the destination fraction, zeros fill below it, and the exponent field is all ones. For example, binary16 0x7E01 becomes binary64 0x7FF8040000000000, and binary32 0x7F800001 becomes binary64 0x7FF0000020000000.
- R2: Narrowing keeps the sign and the most significant destination-width bits of the source fraction. For example, binary64 0xFFF123456789ABCD becomes binary32 0xFF891A2B and binary16 0xFC48.
- R3: If the narrowed fraction is zero, the output is the default NaN of the destination format, whatever the source sign. For example, binary64 0xFFF0000000000001 becomes binary32 0x7FC00000.
- R4: With default-NaN mode set, the output is the destination default NaN for every NaN source. The defaults are 0x7E00, 0x7FC00000 and 0x7FF8000000000000.
- R5: The invalid flag is 1 when the source is a signaling NaN: exponent all ones, top fraction bit 0, remaining fraction nonzero. This holds in default-NaN mode too.
- R6: The invalid flag is 0 for a quiet NaN source (top fraction bit 1) and for any non-NaN source.
- R7: A narrow destination drives zeros on dstVal bits above its width. srcVal bits above the source width have no effect.
- R8: The top fraction bit passes through unchanged. A same-format conversion returns the source pattern bit for bit, signaling NaNs included.
- R9: Format code 3 behaves exactly like code 2 (binary64) on both the source and destination selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcVal | input | 64 | Source NaN, right-aligned for narrow formats |
| srcFmt | input | 2 | Source format code |
| dstFmt | input | 2 | Destination format code |
| defaultNanMode | input | 1 | Force the default NaN on the output |
| dstVal | output | 64 | Converted NaN, right-aligned, upper bits zero |
| invalidFlag | output | 1 | Source was a signaling NaN |

## Verification
The checker examines every settled input combination for four properties. The flag stays low for non-NaN and quiet sources. Default-NaN mode yields the exact default pattern. Bits above a narrow destination stay zero. Every NaN source produces an output with an all-ones exponent and a nonzero fraction. Only the bench's directed scenarios can show that payload bits land in the right positions when widening and narrowing. The same holds for the zero-fraction fallback losing the sign, for same-format identity, and for format code 3 aliasing binary64, because each of these needs a computed expected pattern.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;

  localparam int NUM_FMT = 3;
  localparam int WORD_W  = 64;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_ALIAS  = 2'd3
  } fmtSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] srcIdx;
    logic [1:0] dstIdx;
    logic       forceDefault;
  } convStrobe_t;

  typedef struct packed {
    logic              sign;
    logic [WORD_W-1:0] payload;
  } canonNan_t;

  function automatic int fracWidth(input int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic int expWidth(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  // code 3 folds onto binary64
  function automatic logic [1:0] fmtIndex(input logic [1:0] code);
    return (code == FMT_ALIAS) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/nan_classify.sv
module nan_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [63:0] word,
  output logic        isNan,
  output logic        isSignaling
);
  localparam int TOP_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expAllOnes;

  always_comb begin
    expField    = word[TOP_W-2:FRAC_W];
    fracField   = word[FRAC_W-1:0];
    expAllOnes  = &expField;
    isNan       = expAllOnes && (fracField != '0);
    isSignaling = expAllOnes && !fracField[FRAC_W-1] && (fracField[FRAC_W-2:0] != '0);
  end
endmodule

// File: rtl/nan_ctrl.sv
module nan_ctrl
  import nanconv_pkg::*;
(
  input  logic [63:0]  srcVal,
  input  logic [1:0]   srcFmt,
  input  logic [1:0]   dstFmt,
  input  logic         defaultNanMode,
  output convStrobe_t  strobe,
  output logic         invalidFlag
);
  logic [NUM_FMT-1:0] nanVec;
  logic [NUM_FMT-1:0] snanVec;
  logic [1:0]         srcIdx;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_cls
    nan_classify #(
      .EXP_W (expWidth(g)),
      .FRAC_W(fracWidth(g))
    ) u_cls (
      .word       (srcVal),
      .isNan      (nanVec[g]),
      .isSignaling(snanVec[g])
    );
  end

  always_comb begin
    srcIdx              = fmtIndex(srcFmt);
    strobe.srcIdx       = srcIdx;
    strobe.dstIdx       = fmtIndex(dstFmt);
    strobe.forceDefault = defaultNanMode;
    invalidFlag         = nanVec[srcIdx] && snanVec[srcIdx];
  end
endmodule

// File: rtl/nan_datapath.sv
module nan_datapath
  import nanconv_pkg::*;
#(
  parameter logic [63:0] DEF_HALF   = 64'h0000_0000_0000_7E00,
  parameter logic [63:0] DEF_SINGLE = 64'h0000_0000_7FC0_0000,
  parameter logic [63:0] DEF_DOUBLE = 64'h7FF8_0000_0000_0000
) (
  input  logic [63:0] srcVal,
  input  convStrobe_t strobe,
  output logic [63:0] dstVal
);
  canonNan_t          unpacked [NUM_FMT];
  logic [63:0]        packed_  [NUM_FMT];
  canonNan_t          canon;

  function automatic logic [63:0] defaultFor(input int idx);
    case (idx)
      0:       return DEF_HALF;
      1:       return DEF_SINGLE;
      default: return DEF_DOUBLE;
    endcase
  endfunction

  // source side: shift the encoded word so the fraction top bit reaches bit 63
  for (genvar g = 0; g < NUM_FMT; g++) begin : g_unpack
    localparam int FW    = fracWidth(g);
    localparam int EW    = expWidth(g);
    localparam int TOP_W = 1 + EW + FW;
    localparam int SHAMT = WORD_W - FW;
    logic [63:0] word;
    always_comb begin
      word                = '0;
      word[TOP_W-1:0]     = srcVal[TOP_W-1:0];
      unpacked[g].sign    = srcVal[TOP_W-1];
      unpacked[g].payload = word << SHAMT;
    end
  end

  always_comb begin
    canon = unpacked[0];
    case (strobe.srcIdx)
      2'd0:    canon = unpacked[0];
      2'd1:    canon = unpacked[1];
      default: canon = unpacked[2];
    endcase
  end

  // destination side: rebuild each format from the top of the payload
  for (genvar g = 0; g < NUM_FMT; g++) begin : g_pack
    localparam int FW    = fracWidth(g);
    localparam int EW    = expWidth(g);
    localparam int TOP_W = 1 + EW + FW;
    logic [FW-1:0] fracTop;
    logic [63:0]   rebuilt;
    always_comb begin
      fracTop              = canon.payload[63 -: FW];
      rebuilt              = '0;
      rebuilt[TOP_W-1:0]   = {canon.sign, {EW{1'b1}}, fracTop};
      if (strobe.forceDefault || (fracTop == '0)) packed_[g] = defaultFor(g);
      else                                          packed_[g] = rebuilt;
    end
  end

  always_comb begin
    case (strobe.dstIdx)
      2'd0:    dstVal = packed_[0];
      2'd1:    dstVal = packed_[1];
      default: dstVal = packed_[2];
    endcase
  end
endmodule

// File: rtl/nan_fmt_conv.sv
module nan_fmt_conv
  import nanconv_pkg::*;
#(
  parameter logic [63:0] DEF_HALF   = 64'h0000_0000_0000_7E00,
  parameter logic [63:0] DEF_SINGLE = 64'h0000_0000_7FC0_0000,
  parameter logic [63:0] DEF_DOUBLE = 64'h7FF8_0000_0000_0000
) (
  input  logic [63:0] srcVal,
  input  logic [1:0]  srcFmt,
  input  logic [1:0]  dstFmt,
  input  logic        defaultNanMode,
  output logic [63:0] dstVal,
  output logic        invalidFlag
);
  convStrobe_t strobe;

  nan_ctrl u_ctrl (
    .srcVal        (srcVal),
    .srcFmt        (srcFmt),
    .dstFmt        (dstFmt),
    .defaultNanMode(defaultNanMode),
    .strobe        (strobe),
    .invalidFlag   (invalidFlag)
  );

  nan_datapath #(
    .DEF_HALF  (DEF_HALF),
    .DEF_SINGLE(DEF_SINGLE),
    .DEF_DOUBLE(DEF_DOUBLE)
  ) u_dp (
    .srcVal(srcVal),
    .strobe(strobe),
    .dstVal(dstVal)
  );
endmodule

// File: rtl/nan_fmt_conv_checker.sv
module nan_fmt_conv_checker #(
  parameter logic [63:0] DEF_HALF   = 64'h0000_0000_0000_7E00,
  parameter logic [63:0] DEF_SINGLE = 64'h0000_0000_7FC0_0000,
  parameter logic [63:0] DEF_DOUBLE = 64'h7FF8_0000_0000_0000
) (
  input logic [63:0] srcVal,
  input logic [1:0]  srcFmt,
  input logic [1:0]  dstFmt,
  input logic        defaultNanMode,
  input logic [63:0] dstVal,
  input logic        invalidFlag
);
  logic srcNan, srcQuiet, outIsNan;
  logic [63:0] expDefault;

  always_comb begin
    case (srcFmt)
      2'd0: begin
        srcNan   = (srcVal[14:10] == 5'h1F) && (srcVal[9:0] != 0);
        srcQuiet = srcNan && srcVal[9];
      end
      2'd1: begin
        srcNan   = (srcVal[30:23] == 8'hFF) && (srcVal[22:0] != 0);
        srcQuiet = srcNan && srcVal[22];
      end
      default: begin
        srcNan   = (srcVal[62:52] == 11'h7FF) && (srcVal[51:0] != 0);
        srcQuiet = srcNan && srcVal[51];
      end
    endcase
    case (dstFmt)
      2'd0: begin
        expDefault = DEF_HALF;
        outIsNan   = (dstVal[14:10] == 5'h1F) && (dstVal[9:0] != 0);
      end
      2'd1: begin
        expDefault = DEF_SINGLE;
        outIsNan   = (dstVal[30:23] == 8'hFF) && (dstVal[22:0] != 0);
      end
      default: begin
        expDefault = DEF_DOUBLE;
        outIsNan   = (dstVal[62:52] == 11'h7FF) && (dstVal[51:0] != 0);
      end
    endcase
  end

  always_comb begin
    p_quiet_no_flag_r6: assert (!((!srcNan || srcQuiet) && invalidFlag))
      else $error("flag raised for non-signaling source");
    p_default_mode_r4: assert (!(defaultNanMode && srcNan) || dstVal == expDefault)
      else $error("default mode did not give default NaN");
    p_upper_zero_r7: assert (!(dstFmt == 2'd0 && dstVal[63:16] != 0) &&
                             !(dstFmt == 2'd1 && dstVal[63:32] != 0))
      else $error("bits above narrow destination not zero");
    p_out_nan_r3: assert (!srcNan || outIsNan)
      else $error("NaN source gave non-NaN output");
  end
endmodule

bind nan_fmt_conv nan_fmt_conv_checker #(
  .DEF_HALF  (DEF_HALF),
  .DEF_SINGLE(DEF_SINGLE),
  .DEF_DOUBLE(DEF_DOUBLE)
) u_chk (
  .srcVal        (srcVal),
  .srcFmt        (srcFmt),
  .dstFmt        (dstFmt),
  .defaultNanMode(defaultNanMode),
  .dstVal        (dstVal),
  .invalidFlag   (invalidFlag)
);

// File: tb/nan_fmt_conv_bench.sv
module nan_fmt_conv_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcVal = '0;
  logic [1:0]  srcFmt = 2'd0;
  logic [1:0]  dstFmt = 2'd0;
  logic        defaultNanMode = 1'b0;
  logic [63:0] dstVal;
  logic        invalidFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nan_fmt_conv u_nan_fmt_conv (
    .srcVal        (srcVal),
    .srcFmt        (srcFmt),
    .dstFmt        (dstFmt),
    .defaultNanMode(defaultNanMode),
    .dstVal        (dstVal),
    .invalidFlag   (invalidFlag)
  );

  task automatic apply(input logic [63:0] v, input logic [1:0] sf,
                       input logic [1:0] df, input logic dnm);
    @(negedge clk);
    srcVal = v; srcFmt = sf; dstFmt = df; defaultNanMode = dnm;
    #2;
  endtask

  task automatic chkVal(input string req, input logic [63:0] expV);
    checks++;
    if (dstVal !== expV) begin
      errors++;
      $display("FAIL %s dstVal actual=%h expected=%h", req, dstVal, expV);
    end
  endtask

  task automatic chkFlag(input string req, input logic expF);
    checks++;
    if (invalidFlag !== expF) begin
      errors++;
      $display("FAIL %s invalidFlag actual=%0b expected=%0b", req, invalidFlag, expF);
    end
  endtask

  task automatic t_reset;
    @(posedge clk); rstN = 1'b1;
    apply(64'h0, 2'd0, 2'd0, 1'b0);
    chkFlag("R6 reset zero input", 1'b0);
  endtask

  task automatic t_widen;
    apply(64'h7E01, 2'd0, 2'd2, 1'b0);
    chkVal("R1 half->double", 64'h7FF8040000000000);
    chkFlag("R6 quiet half", 1'b0);
    apply(64'hFE01, 2'd0, 2'd1, 1'b0);
    chkVal("R1 negative half->single", 64'h00000000FFC02000);
    apply(64'h7F800001, 2'd1, 2'd2, 1'b0);
    chkVal("R1 single snan->double", 64'h7FF0000020000000);
    chkFlag("R5 single snan", 1'b1);
  endtask

  task automatic t_narrow;
    apply(64'hFFF123456789ABCD, 2'd2, 2'd1, 1'b0);
    chkVal("R2 double->single", 64'h00000000FF891A2B);
    chkFlag("R5 double snan", 1'b1);
    apply(64'hFFF123456789ABCD, 2'd2, 2'd0, 1'b0);
    chkVal("R2 double->half", 64'h000000000000FC48);
  endtask

  task automatic t_zero_fallback;
    apply(64'hFFF0000000000001, 2'd2, 2'd1, 1'b0);
    chkVal("R3 zero narrowed single", 64'h000000007FC00000);
    apply(64'h7FF0000000000001, 2'd2, 2'd0, 1'b0);
    chkVal("R3 zero narrowed half", 64'h0000000000007E00);
    chkFlag("R5 low-payload snan", 1'b1);
  endtask

  task automatic t_default_mode;
    apply(64'h7E01, 2'd0, 2'd2, 1'b1);
    chkVal("R4 default double", 64'h7FF8000000000000);
    apply(64'hFFC12345, 2'd1, 2'd0, 1'b1);
    chkVal("R4 default half", 64'h0000000000007E00);
    apply(64'h7F812345, 2'd1, 2'd1, 1'b1);
    chkVal("R4 default single", 64'h000000007FC00000);
    chkFlag("R5 snan under default mode", 1'b1);
  endtask

  task automatic t_identity;
    apply(64'h7FA00001, 2'd1, 2'd1, 1'b0);
    chkVal("R8 single snan kept", 64'h000000007FA00001);
    apply(64'hFFFFFFFFFFFFFFFF, 2'd2, 2'd2, 1'b0);
    chkVal("R8 double identity", 64'hFFFFFFFFFFFFFFFF);
  endtask

  task automatic t_upper_bits;
    apply(64'hDEADBEEF00007E01, 2'd0, 2'd1, 1'b0);
    chkVal("R7 upper source ignored", 64'h000000007FC02000);
    chkFlag("R7 upper source no flag", 1'b0);
  endtask

  task automatic t_non_nan;
    apply(64'h7F800000, 2'd1, 2'd2, 1'b0);
    chkFlag("R6 infinity", 1'b0);
    apply(64'h3FF0000000000000, 2'd2, 2'd0, 1'b0);
    chkFlag("R6 ordinary number", 1'b0);
  endtask

  task automatic t_alias;
    apply(64'h7FF4000000000005, 2'd3, 2'd3, 1'b0);
    chkVal("R9 code3 identity", 64'h7FF4000000000005);
    chkFlag("R9 code3 snan", 1'b1);
    apply(64'h7E01, 2'd0, 2'd3, 1'b0);
    chkVal("R9 code3 destination", 64'h7FF8040000000000);
  endtask

  initial begin
    t_reset();
    t_widen();
    t_narrow();
    t_zero_fallback();
    t_default_mode();
    t_identity();
    t_upper_bits();
    t_non_nan();
    t_alias();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule